// File: doc/BRIEF.md
# Clock Divider Output Sync Controller

This block keeps a bank of programmable clock dividers in phase when they are all fed from one fast input clock. It gathers every reason to resynchronise into a single internal request. The sources are an active-low external sync pin, an active-low power-down pin, a calibration-busy flag, three register bits written through a small strobe port, and the block's own reset. While any request is present, every divider output is forced low and every divider counter is cleared.

When the last request goes away, the block runs a fixed restart countdown. The countdown is 14 channel-clock ticks plus one extra input cycle. After it ends, all dividers start together from count zero, so every output has its first rising edge in the same cycle. An optional prescaler, modelled as a clock enable on the fast clock, can sit ahead of the channel dividers. When the prescaler is used, one channel tick equals `pre_ratio` fast cycles; when it is bypassed, one tick equals one fast cycle.

The register port is a single write strobe with a 2-bit select and one data bit:

| Select | Meaning |
|---|---|
| 0 | Soft-sync shadow bit |
| 1 | Soft reset |
| 2 | Distribution power-down |
| 3 | Update strobe; the data bit is ignored |

The soft-sync bit acts only through its live copy. That live copy is loaded from the shadow copy only by an update strobe.

Top module: `div_phase_align`

## Requirements
- R1: While `rst_n` is low, `ch_out` is all zero and `sync_busy` is 1. After reset is released with no other request present, the outputs restart automatically within the R8 window.
- R2: Holding `sync_pin_n` low holds the outputs static. Releasing it starts the restart countdown. The pin passes through a two-flop synchronizer.
- R3: Holding `pd_pin_n` low acts like the sync pin: the outputs stay static while it is low, and the restart begins when it is released.
- R4: A write with `wr_sel`=0 changes only the soft-sync shadow bit. The live bit, which requests sync while it is 1, loads from the shadow only on a write with `wr_sel`=3. Both setting and clearing the shadow bit have no effect until that strobe arrives.
- R5: A write with `wr_sel`=1 (soft reset) or `wr_sel`=2 (distribution power-down) takes effect at once. The bit requests sync while it is 1.
- R6: `cal_busy`=1 requests sync. Its fall starts the restart.
- R7: While any request is present, every `ch_out` bit is 0 and `sync_busy` is 1. This holds from the cycle after the merged request, which is three cycles after a pin falls.
- R8: The cycles from the release of the last request to the first high output lie between 14·T+1 and 15·T+5 fast cycles. T is `pre_ratio` when `pre_use`=1, and 1 otherwise.
- R9: On restart, every channel goes high in the same cycle, whatever its ratio.
- R10: Channel i takes its ratio N from `div_ratio[5i+4:5i]`, which encodes N−1, so N runs from 1 to 32. The output period is N·T fast cycles. The output is high for max(1, floor(N/2))·T cycles, starting at count zero.
- R11: A request that arrives during the restart countdown aborts it and keeps the outputs low. The next restart latency is measured from the later release.
- R12: When `pre_use`=0, the channel dividers advance every fast cycle and `pre_ratio` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock feeding the prescaler and the channels |
| rst_n | input | 1 | Synchronous active-low reset; also acts as the power-up sync |
| sync_pin_n | input | 1 | Asynchronous active-low sync request pin |
| pd_pin_n | input | 1 | Asynchronous active-low power-down pin |
| cal_busy | input | 1 | Calibration in progress; requests sync while high |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 soft-sync shadow, 1 soft reset, 2 distribution power-down, 3 update |
| wr_bit | input | 1 | Write data bit |
| pre_use | input | 1 | 1 routes the channels through the prescaler enable |
| pre_ratio | input | PRE_W | Prescaler ratio; 0 is treated as 1 |
| div_ratio | input | N_CH*RW | Per-channel ratio minus one, channel i at bits [RW*i+RW-1:RW*i] |
| ch_out | output | N_CH | Divider outputs |
| sync_busy | output | 1 | High while outputs are held or the countdown is running |

## Verification
The bench goes after the shadow-register path: a soft-sync write without an update must leave the outputs running. A design that loaded the live bit directly would stop the clocks early, or would fail to restart until the clearing update arrives. It also cuts a countdown short with a fresh request. A design that ignored the abort would restart while the request is still present, and its latency would be counted from the wrong release. With random ratios, odd and even, from 1 to 32, and random prescale settings, the bench measures the latency window and the relative phase at restart. It then compares every channel waveform cycle by cycle, which exposes an off-by-one tick count, a skewed channel, or a wrong high time for odd ratios.

// File: rtl/dpa_pkg.sv
// Shared definitions for the divider phase-alignment block.
// Assumes: a single fast clock domain; all selects are 2-bit codes.
package dpa_pkg;
    typedef enum logic [1:0] {
        ST_HOLD  = 2'd0,
        ST_COUNT = 2'd1,
        ST_EXTRA = 2'd2,
        ST_RUN   = 2'd3
    } seq_state_t;

    localparam logic [1:0] SEL_SOFT_SYNC = 2'd0;
    localparam logic [1:0] SEL_SOFT_RST  = 2'd1;
    localparam logic [1:0] SEL_DIST_PD   = 2'd2;
    localparam logic [1:0] SEL_UPDATE    = 2'd3;
endpackage

// File: rtl/dpa_req_merge.sv
// Merges every sync source into one request.
// Assumes: the pins are asynchronous and pass through STAGES flops each;
// cal_busy and the write port are already synchronous to clk.
module dpa_req_merge
    import dpa_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sync_pin_n,
    input  logic       pd_pin_n,
    input  logic       cal_busy,
    input  logic       wr_en,
    input  logic [1:0] wr_sel,
    input  logic       wr_bit,
    output logic       req,
    output logic       soft_live
);
    localparam int NPIN = 2;

    logic [NPIN-1:0] pin_raw;
    logic [NPIN-1:0] pin_sync;
    logic            soft_shadow;
    logic            soft_rst;
    logic            dist_pd;

    assign pin_raw = {pd_pin_n, sync_pin_n};

    for (genvar gi = 0; gi < NPIN; gi++) begin : g_pin
        logic [STAGES-1:0] chain;
        // Purpose: resynchronise one active-low pin; resets to the inactive level.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2:0], pin_raw[gi]};
        end
        assign pin_sync[gi] = chain[STAGES-1];
    end

    // Purpose: hold the soft-control bits and copy the shadow into the live bit on update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            soft_shadow <= 1'b0;
            soft_live   <= 1'b0;
            soft_rst    <= 1'b0;
            dist_pd     <= 1'b0;
        end else if (wr_en) begin
            unique case (wr_sel)
                SEL_SOFT_SYNC: soft_shadow <= wr_bit;
                SEL_SOFT_RST:  soft_rst    <= wr_bit;
                SEL_DIST_PD:   dist_pd     <= wr_bit;
                SEL_UPDATE:    soft_live   <= soft_shadow;
                default:       ;
            endcase
        end
    end

    assign req = ~&pin_sync | soft_live | soft_rst | dist_pd | cal_busy;
endmodule

// File: rtl/dpa_restart_seq.sv
// Prescaler enable and restart sequencer.
// Assumes: req is synchronous; a ratio of 0 means 1. The prescaler phase is
// cleared in HOLD and EXTRA, so every channel period starts cleanly in RUN.
module dpa_restart_seq
    import dpa_pkg::*;
#(
    parameter int LAT_TICKS = 14,
    parameter int PRE_W     = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             pre_use,
    input  logic [PRE_W-1:0] pre_ratio,
    output logic             tick,
    output logic             run,
    output logic             busy
);
    localparam int LW = $clog2(LAT_TICKS + 1);

    seq_state_t       state;
    logic [LW-1:0]    lat_cnt;
    logic [PRE_W-1:0] pc;
    logic [PRE_W-1:0] eff_m1;

    assign eff_m1 = (pre_ratio == '0) ? '0 : pre_ratio - 1'b1;
    assign tick   = pre_use ? (pc == eff_m1) : 1'b1;
    assign run    = (state == ST_RUN);
    assign busy   = ~run;

    // Purpose: run the prescaler counter only while counting down or running.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   pc <= '0;
        else if (state == ST_HOLD || state == ST_EXTRA) pc <= '0;
        else if (pre_use)                             pc <= tick ? '0 : pc + 1'b1;
    end

    // Purpose: hold on request, count the restart latency, then release the channels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_HOLD;
            lat_cnt <= '0;
        end else if (req) begin
            state   <= ST_HOLD;
            lat_cnt <= '0;
        end else begin
            unique case (state)
                ST_HOLD: begin
                    state   <= ST_COUNT;
                    lat_cnt <= '0;
                end
                ST_COUNT: if (tick) begin
                    if (lat_cnt == LW'(LAT_TICKS - 1)) state <= ST_EXTRA;
                    else                               lat_cnt <= lat_cnt + 1'b1;
                end
                ST_EXTRA: if (pre_use || tick) state <= ST_RUN;
                ST_RUN:   ;
                default:  state <= ST_HOLD;
            endcase
        end
    end
endmodule

// File: rtl/dpa_chan_div.sv
// One channel divider running on a clock enable.
// Assumes: the counter sits at zero whenever run is low; the ratio is encoded
// as N-1; the high time is max(1, floor(N/2)) ticks, starting at count zero.
module dpa_chan_div #(
    parameter int RW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          en,
    input  logic [RW-1:0] ratio_m1,
    output logic          clk_out
);
    logic [RW-1:0] cnt;
    logic [RW:0]   n_full;
    logic [RW:0]   hi_raw;
    logic [RW:0]   hi_cnt;

    assign n_full = {1'b0, ratio_m1} + 1'b1;
    assign hi_raw = n_full >> 1;
    assign hi_cnt = (hi_raw == '0) ? (RW+1)'(1) : hi_raw;

    // Purpose: step the channel count on each enabled tick, wrapping at N-1.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)       cnt <= '0;
        else if (en)              cnt <= (cnt >= ratio_m1) ? '0 : cnt + 1'b1;
    end

    assign clk_out = run && ({1'b0, cnt} < hi_cnt);
endmodule

// File: rtl/div_phase_align.sv
// Top of the divider phase-alignment block: the request merge, the restart
// sequencer and N_CH channel dividers that share one enable.
// Assumes: one fast clock; the ratios change only while the outputs are held.
module div_phase_align #(
    parameter int N_CH        = 4,
    parameter int RW          = 5,
    parameter int PRE_W       = 3,
    parameter int LAT_TICKS   = 14,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_pin_n,
    input  logic              pd_pin_n,
    input  logic              cal_busy,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic              wr_bit,
    input  logic              pre_use,
    input  logic [PRE_W-1:0]  pre_ratio,
    input  logic [N_CH*RW-1:0] div_ratio,
    output logic [N_CH-1:0]   ch_out,
    output logic              sync_busy
);
    logic sync_req;
    logic soft_live;
    logic tick;
    logic run;

    dpa_req_merge #(.STAGES(SYNC_STAGES)) u_merge (
        .clk(clk), .rst_n(rst_n), .sync_pin_n(sync_pin_n), .pd_pin_n(pd_pin_n),
        .cal_busy(cal_busy), .wr_en(wr_en), .wr_sel(wr_sel), .wr_bit(wr_bit),
        .req(sync_req), .soft_live(soft_live)
    );

    dpa_restart_seq #(.LAT_TICKS(LAT_TICKS), .PRE_W(PRE_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .req(sync_req), .pre_use(pre_use),
        .pre_ratio(pre_ratio), .tick(tick), .run(run), .busy(sync_busy)
    );

    for (genvar ci = 0; ci < N_CH; ci++) begin : g_ch
        dpa_chan_div #(.RW(RW)) u_div (
            .clk(clk), .rst_n(rst_n), .run(run), .en(tick),
            .ratio_m1(div_ratio[ci*RW +: RW]), .clk_out(ch_out[ci])
        );
    end
endmodule

// File: rtl/dpa_checker.sv
// Property checker for div_phase_align, attached by the bind below.
// Assumes: it sees the merged request and the live soft-sync bit of the top.
module dpa_checker #(
    parameter int N_CH      = 4,
    parameter int LAT_TICKS = 14
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req,
    input logic            soft_live,
    input logic            wr_en,
    input logic [1:0]      wr_sel,
    input logic [N_CH-1:0] ch_out,
    input logic            sync_busy
);
    logic [15:0] since_rel;

    // Purpose: count the cycles since the merged request last went away.
    always_ff @(posedge clk) begin
        if (!rst_n || req)          since_rel <= '0;
        else if (since_rel != '1)   since_rel <= since_rel + 1'b1;
    end

    a_r7_static_on_req: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> (ch_out == '0) && sync_busy);

    a_r9_in_phase: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sync_busy) |-> (&ch_out));

    a_r4_live_needs_update: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_sel == 2'd3) |=> $stable(soft_live));

    a_r8_min_latency: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sync_busy) |-> (since_rel >= 16'(LAT_TICKS + 1)));

    a_r11_abort_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (req && sync_busy) |=> sync_busy);
endmodule

bind div_phase_align dpa_checker #(.N_CH(N_CH), .LAT_TICKS(LAT_TICKS)) u_chk (
    .clk(clk), .rst_n(rst_n), .req(sync_req), .soft_live(soft_live),
    .wr_en(wr_en), .wr_sel(wr_sel), .ch_out(ch_out), .sync_busy(sync_busy)
);

// File: tb/sim_div_phase_align.sv
module sim_div_phase_align;
    localparam int N_CH = 4;
    localparam int RW   = 5;
    localparam int PW   = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sync_pin_n = 1'b1, pd_pin_n = 1'b1, cal_busy = 1'b0;
    logic wr_en = 1'b0, wr_bit = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic pre_use = 1'b0;
    logic [PW-1:0] pre_ratio = 3'd1;
    logic [N_CH*RW-1:0] div_ratio = '0;
    logic [N_CH-1:0] ch_out;
    logic sync_busy;

    int tests = 0, fails = 0, cyc = 0;
    int rat [N_CH];
    bit done = 0;

    always #10 clk = ~clk;

    div_phase_align u0 (
        .clk(clk), .rst_n(rst_n), .sync_pin_n(sync_pin_n), .pd_pin_n(pd_pin_n),
        .cal_busy(cal_busy), .wr_en(wr_en), .wr_sel(wr_sel), .wr_bit(wr_bit),
        .pre_use(pre_use), .pre_ratio(pre_ratio), .div_ratio(div_ratio),
        .ch_out(ch_out), .sync_busy(sync_busy)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 190000 && !done) begin
            fails = fails + 1;
            $display("FAIL watchdog expired: actual cycle %0d expected < 190000", cyc);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    function automatic int tper();
        return pre_use ? ((pre_ratio == 0) ? 1 : int'(pre_ratio)) : 1;
    endfunction

    function automatic bit exp_bit(int n, int t_per, int t);
        int c, h;
        c = (t / t_per) % n;
        h = n / 2;
        if (h == 0) h = 1;
        return c < h;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_ratios();
        for (int i = 0; i < N_CH; i++) div_ratio[i*RW +: RW] = RW'(rat[i] - 1);
    endtask

    task automatic wr(logic [1:0] s, logic b);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_bit = b;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic assert_src(int s);
        case (s)
            0: begin @(negedge clk); sync_pin_n = 1'b0; end
            1: begin @(negedge clk); pd_pin_n = 1'b0; end
            2: begin wr(2'd0, 1'b1); wr(2'd3, 1'b0); end
            3: wr(2'd1, 1'b1);
            4: wr(2'd2, 1'b1);
            default: begin @(negedge clk); cal_busy = 1'b1; end
        endcase
    endtask

    task automatic release_src(int s);
        case (s)
            0: begin @(negedge clk); sync_pin_n = 1'b1; end
            1: begin @(negedge clk); pd_pin_n = 1'b1; end
            2: begin wr(2'd0, 1'b0); wr(2'd3, 1'b0); end
            3: wr(2'd1, 1'b0);
            4: wr(2'd2, 1'b0);
            default: begin @(negedge clk); cal_busy = 1'b0; end
        endcase
    endtask

    // R7: outputs low and busy high for n cycles (after settling)
    task automatic hold_check(int n, string req);
        int errs = 0;
        repeat (4) @(negedge clk);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (ch_out != 0 || !sync_busy) errs++;
        end
        chk(errs == 0, req, errs, 0);
    endtask

    // R8, R9, R10 after a release
    task automatic restart_check(string req);
        int n = 0, t_per, lo, hi, errs, maxn, len;
        t_per = tper();
        lo = 14 * t_per + 1;
        hi = 15 * t_per + 5;
        do begin
            @(negedge clk);
            n++;
        end while (ch_out == 0 && n < hi + 40);
        chk(n >= lo && n <= hi, {req, " R8 latency"}, n, lo);
        chk(ch_out == '1, {req, " R9 in phase"}, int'(ch_out), (1 << N_CH) - 1);
        maxn = 1;
        for (int i = 0; i < N_CH; i++) if (rat[i] > maxn) maxn = rat[i];
        len = 2 * maxn * t_per;
        errs = 0;
        for (int t = 1; t < len; t++) begin
            @(negedge clk);
            for (int i = 0; i < N_CH; i++)
                if (ch_out[i] != exp_bit(rat[i], t_per, t)) errs++;
        end
        chk(errs == 0, {req, " R10 waveform"}, errs, 0);
    endtask

    initial begin
        int dummy;
        string tag;
        dummy = $urandom(32'd2024);
        rat[0] = 1; rat[1] = 2; rat[2] = 7; rat[3] = 32;
        set_ratios();
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(ch_out == 0, "R1 reset outputs", int'(ch_out), 0);
        chk(sync_busy == 1'b1, "R1 reset busy", int'(sync_busy), 1);
        rst_n = 1'b1;
        restart_check("R1 power-up");

        // R4: shadow write without update has no effect
        wr(2'd0, 1'b1);
        repeat (20) @(negedge clk);
        chk(sync_busy == 1'b0, "R4 shadow set ignored", int'(sync_busy), 0);
        wr(2'd3, 1'b0);
        hold_check(10, "R4 update holds");
        wr(2'd0, 1'b0);
        repeat (30) @(negedge clk);
        chk(sync_busy == 1'b1 && ch_out == 0, "R4 shadow clear ignored",
            int'(sync_busy), 1);
        wr(2'd3, 1'b0);
        restart_check("R4 restart");

        // R11: abort during countdown
        assert_src(0);
        hold_check(5, "R2 pin hold");
        release_src(0);
        repeat (8) @(negedge clk);
        chk(sync_busy == 1'b1 && ch_out == 0, "R11 mid countdown", int'(ch_out), 0);
        @(negedge clk); cal_busy = 1'b1;
        hold_check(20, "R11 abort holds");
        release_src(5);
        restart_check("R11 later release");

        // R12: bypass ignores pre_ratio
        assert_src(4);
        pre_use = 1'b0; pre_ratio = 3'd7;
        rat[0] = 3; rat[1] = 5; rat[2] = 4; rat[3] = 9;
        set_ratios();
        hold_check(5, "R5 dist pd hold");
        release_src(4);
        restart_check("R12 bypass");

        // random mix over sources, ratios and prescale
        for (int it = 0; it < 24; it++) begin
            int s;
            s = int'($urandom % 6);
            assert_src(s);
            pre_use = 1'($urandom % 2);
            pre_ratio = PW'(1 + $urandom % 7);
            for (int i = 0; i < N_CH; i++) rat[i] = 1 + int'($urandom % 32);
            set_ratios();
            case (s)
                0: tag = "R2 pin";
                1: tag = "R3 pd pin";
                2: tag = "R4 soft sync";
                3: tag = "R5 soft reset";
                4: tag = "R5 dist pd";
                default: tag = "R6 cal busy";
            endcase
            hold_check(5 + int'($urandom % 16), {tag, " R7 static"});
            release_src(s);
            restart_check(tag);
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule